// File: doc/BRIEF.md
# Coded-Duty Fixed-Rate PWM Generator

This block drives a single pulse-width-modulated level at a fixed 20 kHz switching rate from a 50 MHz system clock. It takes a 4-bit duty code rather than a proportional duty word. The code is decoded through a small table with four kinds of entry: ten steps of one tenth each, a 75 % entry, a 98 % ceiling, and a 50 % fallback for the codes that are left over.

Each period starts with the output high. The output drops once the period counter reaches the threshold decoded from the code. The code is sampled only as a new period begins. A code can therefore change at any time without cutting a pulse short or stretching it. The block suits a power stage or a lamp dimmer, with a front panel or a controller setting the code.

Top module: `pwm_table_duty`

## Requirements
- R1: Every PWM period lasts exactly 2500 clock cycles. The internal period counter counts 0 to 2499 and then returns to 0.
- R2: Codes 0 to 9 (binary 0000 to 1001) give a high time of 250 × code cycles in each period.
- R3: Code 15 (binary 1111) gives a high time of 2450 cycles in each period (98 %).
- R4: Code 14 (binary 1110) gives a high time of 1875 cycles in each period (75 %).
- R5: Codes 10 to 13 (binary 1010 to 1101) give a high time of 1250 cycles in each period (50 %).
- R6: Within a period the output is high for one unbroken run that starts at the first cycle of the period, then stays low until the period ends.
- R7: The code is sampled only when a new period begins. If the code changes while a pulse is in progress, that pulse finishes at its old width, and the new width starts with the next period.
- R8: While code 0 is in effect, the output stays low for the whole period, including the cycle where the counter wraps.
- R9: Driving rst_n low forces pwm_out low at once, without waiting for a clock, and clears the counter. After rst_n goes high, the release passes through a two-stage synchronizer. The first period after reset runs with code 0, so pwm_out first rises on the 2502nd rising clock edge after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| duty_code | input | 4 | Duty selection code, sampled at each period start |
| pwm_out | output | 1 | Registered PWM level |

## Verification
The bench measures each pulse's width and the spacing of its rising edges for all sixteen codes. It does this for three reasons. A decoder that scales the code proportionally would give the wrong widths for codes 10 to 15. A counter that is off by one would show a period of 2499 or 2501 cycles. A compare written as less-or-equal would add one high cycle to every pulse.

It changes the code partway through a pulse. A design that applies the code at once would end that pulse early, at 500 cycles, not 2250. It moves to code 0 and watches two full periods. A compare done in the wrong cycle would leak a one-cycle spike at the wrap.

It also resets in the middle of a pulse and counts the low cycles after release. An output that does not clear at once, or a release path of the wrong length, would both show up in that count.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // High-time threshold, in clock cycles, for a given duty code and period.
  function automatic int unsigned duty_thresh(input logic [3:0] code,
                                              input int unsigned period);
    int unsigned t;
    if (code <= 4'd9) begin
      t = (period * int'(code)) / 10;
    end else if (code == 4'hF) begin
      t = (period * 98) / 100;
    end else if (code == 4'hE) begin
      t = (period * 3) / 4;
    end else begin
      t = period / 2;
    end
    return t;
  endfunction

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int PERIOD = 2500,
  parameter int CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R1: counter never leaves its range
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R1: last count is followed by zero
  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_duty_decode.sv
module pwm_duty_decode #(
  parameter int PERIOD = 2500,
  parameter int TW     = $clog2(PERIOD + 1)
) (
  input  logic [3:0]    code,
  output logic [TW-1:0] thresh
);
  import pwm_pkg::*;

  // Sixteen thresholds computed once at elaboration.
  logic [TW-1:0] lut [16];

  for (genvar g = 0; g < 16; g++) begin : g_lut
    assign lut[g] = TW'(duty_thresh(4'(g), PERIOD));
  end

  always_comb begin
    thresh = lut[code];
  end
endmodule

// File: rtl/pwm_table_duty.sv
module pwm_table_duty #(
  parameter int CLK_HZ = 50_000_000,
  parameter int PWM_HZ = 20_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] duty_code,
  output logic       pwm_out
);
  localparam int PERIOD = CLK_HZ / PWM_HZ;
  localparam int CW     = $clog2(PERIOD);
  localparam int TW     = $clog2(PERIOD + 1);

  logic          rst_sync_n;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          wrap;
  logic [3:0]    code_q;
  logic [3:0]    code_nxt;
  logic [TW-1:0] thr_nxt;
  logic          pwm_d;
  logic          pwm_q;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_period_ctr #(.PERIOD(PERIOD), .CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  // Decode the code that will be active next cycle, so the compare
  // lines up with the registered output.
  pwm_duty_decode #(.PERIOD(PERIOD), .TW(TW)) u_dec (
    .code   (code_nxt),
    .thresh (thr_nxt)
  );

  always_comb begin
    code_nxt = wrap ? duty_code : code_q;
    pwm_d    = ({{(TW-CW){1'b0}}, cnt_nxt} < thr_nxt);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      if (wrap) code_q <= duty_code;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_out = pwm_q;

  // R7: latched code moves only on entry to count zero
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_q != '0) |-> $stable(code_q));

  // R6: a pulse can only begin at the first cycle of a period
  assert_rise_at_start_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pwm_q) |-> (cnt_q == '0));

  // R8: zero code keeps the output low
  assert_zero_low_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (code_q == 4'd0) |-> !pwm_q);

  // R3: no code reaches a full-period pulse; last cycle of a period is low
  assert_last_low_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wrap |-> !pwm_q);

  // R9: output stays low while reset is applied
  assert_reset_low_R9: assert property (@(posedge clk)
    !rst_sync_n |-> !pwm_q);
endmodule

// File: tb/tb_pwm_table_duty.sv
module tb_pwm_table_duty;
  localparam int PERIOD = 2500;

  // Expected high time per code, from R2..R5.
  localparam int EXP_HI [16] = '{
    0, 250, 500, 750, 1000, 1250, 1500, 1750, 2000, 2250,
    1250, 1250, 1250, 1250, 1875, 2450
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] duty_code;
  logic       pwm_out;

  int n_run  = 0;
  int n_fail = 0;

  pwm_table_duty dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .duty_code (duty_code),
    .pwm_out   (pwm_out)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for a fresh rising edge, then measure high run and period.
  task automatic measure(output int hi, output int per);
    int lo;
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    hi = 0;
    while (pwm_out) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pwm_out) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hi, per, lo, cnt;
    rst_n     = 1'b0;
    duty_code = 4'd0;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R9 reset level", pwm_out, 0);
    rst_n = 1'b1;

    // Vector table over every code.
    for (int c = 0; c < 16; c++) begin
      duty_code = 4'(c);
      if (EXP_HI[c] == 0) begin
        repeat (2 * PERIOD) @(negedge clk);
        cnt = 0;
        for (int k = 0; k < PERIOD; k++) begin
          if (pwm_out) cnt++;
          @(negedge clk);
        end
        check(cnt == 0, "R2 code0 high", cnt, 0);
      end else begin
        measure(hi, per);
        if (c <= 9)       check(hi == EXP_HI[c], "R2 high", hi, EXP_HI[c]);
        else if (c == 15) check(hi == EXP_HI[c], "R3 high", hi, EXP_HI[c]);
        else if (c == 14) check(hi == EXP_HI[c], "R4 high", hi, EXP_HI[c]);
        else              check(hi == EXP_HI[c], "R5 high", hi, EXP_HI[c]);
        check(per == PERIOD, "R1 period", per, PERIOD);
      end
    end

    // R6/R7: change code partway through a pulse.
    duty_code = 4'd9;
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    hi = 0;
    repeat (100) begin hi++; @(negedge clk); end
    duty_code = 4'd2;
    while (pwm_out) begin hi++; @(negedge clk); end
    check(hi == 2250, "R7 old width kept", hi, 2250);
    lo = 0;
    while (!pwm_out) begin lo++; @(negedge clk); end
    check(hi + lo == PERIOD, "R6 single run per period", hi + lo, PERIOD);
    hi = 0;
    while (pwm_out) begin hi++; @(negedge clk); end
    check(hi == 500, "R7 new width next period", hi, 500);

    // R8: switch to zero, no spike across two wraps.
    duty_code = 4'd0;
    repeat (PERIOD) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 2 * PERIOD; k++) begin
      if (pwm_out) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R8 zero no glitch", cnt, 0);
    duty_code = 4'd1;
    measure(hi, per);
    check(hi == 250, "R2 recover from zero", hi, 250);

    // R9: reset in the middle of a pulse, then release.
    duty_code = 4'd5;
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pwm_out == 1'b0, "R9 async clear", pwm_out, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lo = 0;
    @(negedge clk);
    while (!pwm_out) begin lo++; @(negedge clk); end
    check(lo == 2501, "R9 low after release", lo, 2501);
    hi = 0;
    while (pwm_out) begin hi++; @(negedge clk); end
    check(hi == 1250, "R9 first pulse width", hi, 1250);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule